// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Register File

This block is a clock/calendar register file that sits in the highest sixteen locations of a byte-wide memory space. It decodes every bus address. An access that falls inside this window is served by the block itself, and the chip-enable passed on to the external RAM is held inactive. Every other access leaves the RAM chip-enable equal to the bus chip-enable.

Time is held twice, as 24-hour packed BCD. An internal set advances on every one-second tick whenever the oscillator-stop bit is clear. An external set is the copy that software reads and writes. A freeze bit stops the external copy from following the internal one, so that software can read a stable snapshot. A write bit also stops that tracking. When the write bit is cleared, the values software wrote are loaded into the internal set. A single tick carries a rollover through every field, from seconds up to century. Month lengths and leap years follow the Gregorian calendar, including the 400-year rule.

Top module: `bcd_calendar_regs`

## Requirements
- R1: When the address bits above the low WIN_BITS bits are all ones (the clock window), `ramCeN` is 1. Outside the window, `ramCeN` equals `busCeN`.
- R2: `busRdEn` is 1 only for a window hit with `busCeN`=0, `busOeN`=0 and `busWeN`=1. In that case `busRdData` shows the addressed register at once. At all other times `busRdEn` and `busRdData` are 0. Window offsets: 0 second, 1 minute, 2 hour, 3 weekday, 4 date, 5 month, 6 year, 7 century, 8 control. Offsets 9 to 15 read as 00 and ignore writes.
- R3: On every cycle with `tick1Hz`=1 and the oscillator-stop bit clear, the internal set advances by one second, whatever the control bits hold.
- R4: While control bit 6 (freeze) is 1, the external copy does not follow the internal set. It keeps the time of the last tick before the freeze was written.
- R5: While control bit 7 (write) is 1, the external copy does not follow the internal set. Writing control with bit 7 = 0 while it was 1 loads the external values into the internal set at that edge.
- R6: The fields hold packed BCD in these ranges: second and minute 00-59, hour 00-23, weekday 01-07, date 01-31, month 01-12, year 00-99, century 00-39. One tick cascades a rollover through second, minute, hour, date and weekday, month, year and century. The weekday wraps from 07 to 01, and century 39 wraps to 00.
- R7: Date rollover uses the month length: 30 days for months 04, 06, 09 and 11; 31 days for the others; February has 29 days in a leap year and 28 otherwise. A year is a leap year when it is divisible by 4. Year 00 is a leap year only when the century is divisible by 4.
- R8: Bit 7 of the second register (offset 0) is the oscillator-stop bit. While it is 1, the internal set holds its value. The bit reads back at bit 7 of offset 0.
- R9: After the freeze and write bits are both clear, the first tick loads the advanced internal time into the external copy.
- R10: After reset, the time reads as century 20, year 00, month 01, date 01, weekday 01, 00:00:00, and control and the oscillator-stop bit read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Bus address |
| busCeN | input | 1 | Bus chip-enable, active low |
| busOeN | input | 1 | Bus output-enable, active low |
| busWeN | input | 1 | Bus write-enable, active low; a write is taken at the clock edge |
| busWrData | input | 8 | Write data |
| tick1Hz | input | 1 | One-cycle pulse per second |
| busRdData | output | 8 | Read data, 0 when not reading |
| busRdEn | output | 1 | Read data valid (drive the bus) |
| ramCeN | output | 1 | Chip-enable passed on to the external RAM, active low |

## Verification
Chip-enable steering and read data are combinational, so the bench checks them one nanosecond after it drives the bus, well before the next edge. A register write or a tick lands at the one rising edge it spans. The bench therefore reads the new value back on a later cycle and never within the same cycle. The internal set is never observed directly. A freeze or a stopped oscillator is checked by releasing the hold, giving exactly one more tick, and comparing the count read back with the number of ticks the requirements say the internal set has seen.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [7:0] century;
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] weekday;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] second;
  } calTime_t;

  typedef struct packed {
    logic       advance;
    logic       transfer;
    logic       refresh;
    logic       fieldWr;
    logic [2:0] fieldSel;
    logic [7:0] fieldData;
  } calStrb_t;

  localparam calTime_t RESET_TIME = '{century: 8'h20, year: 8'h00, month: 8'h01,
                                      date: 8'h01, weekday: 8'h01, hour: 8'h00,
                                      minute: 8'h00, second: 8'h00};

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic div4(input logic [7:0] v);
    if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
    return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] lastDay(input logic [7:0] month, input logic leap);
    case (month)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] fieldMask(input logic [2:0] sel);
    case (sel)
      3'd0, 3'd1: return 8'h7F;
      3'd2, 3'd4, 3'd7: return 8'h3F;
      3'd3: return 8'h07;
      3'd5: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic calTime_t nextTime(input calTime_t t);
    calTime_t n;
    logic     leap;
    n    = t;
    leap = (t.year == 8'h00) ? div4(t.century) : div4(t.year);
    if (t.second < 8'h59) n.second = bcdInc(t.second);
    else begin
      n.second = 8'h00;
      if (t.minute < 8'h59) n.minute = bcdInc(t.minute);
      else begin
        n.minute = 8'h00;
        if (t.hour < 8'h23) n.hour = bcdInc(t.hour);
        else begin
          n.hour    = 8'h00;
          n.weekday = (t.weekday >= 8'h07) ? 8'h01 : bcdInc(t.weekday);
          if (t.date < lastDay(t.month, leap)) n.date = bcdInc(t.date);
          else begin
            n.date = 8'h01;
            if (t.month < 8'h12) n.month = bcdInc(t.month);
            else begin
              n.month = 8'h01;
              if (t.year < 8'h99) n.year = bcdInc(t.year);
              else begin
                n.year    = 8'h00;
                n.century = (t.century >= 8'h39) ? 8'h00 : bcdInc(t.century);
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  calStrb_t strb,
  output calTime_t timeInt,
  output calTime_t timeExt
);

  localparam int FIELDS = 8;

  calTime_t    intNext;
  logic [63:0] extFlat;
  logic [63:0] extNextFlat;

  assign intNext = nextTime(timeInt);

  always_comb begin
    extFlat     = timeExt;
    extNextFlat = strb.refresh ? (strb.advance ? intNext : timeInt) : extFlat;
    for (int f = 0; f < FIELDS; f++) begin
      if (strb.fieldWr && (strb.fieldSel == 3'(f)))
        extNextFlat[f*8 +: 8] = strb.fieldData & fieldMask(3'(f));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeInt <= RESET_TIME;
      timeExt <= RESET_TIME;
    end else begin
      if (strb.transfer)     timeInt <= timeExt;
      else if (strb.advance) timeInt <= intNext;
      timeExt <= calTime_t'(extNextFlat);
    end
  end

endmodule

// File: rtl/cal_control.sv
module cal_control
  import cal_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int WIN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busCeN,
  input  logic              busOeN,
  input  logic              busWeN,
  input  logic [7:0]        busWrData,
  input  logic              tick1Hz,
  input  calTime_t          timeExt,
  output calStrb_t          strb,
  output logic [7:0]        busRdData,
  output logic              busRdEn,
  output logic              ramCeN
);

  localparam logic [WIN_BITS-1:0] CTL_OFF = WIN_BITS'(8);

  logic                winHit;
  logic [WIN_BITS-1:0] off;
  logic                wrStb;
  logic                fieldWr;
  logic                ctlWr;
  logic                freezeBit;
  logic                writeBit;
  logic                oscStop;
  logic [63:0]         extFlat;

  assign winHit  = &busAddr[ADDR_W-1:WIN_BITS];
  assign off     = busAddr[WIN_BITS-1:0];
  assign wrStb   = winHit && !busCeN && !busWeN;
  assign fieldWr = wrStb && (off < CTL_OFF);
  assign ctlWr   = wrStb && (off == CTL_OFF);
  assign ramCeN  = busCeN | winHit;
  assign extFlat = timeExt;

  always_comb begin
    strb.advance   = tick1Hz && !oscStop;
    strb.transfer  = ctlWr && writeBit && !busWrData[7];
    strb.refresh   = tick1Hz && !freezeBit && !writeBit;
    strb.fieldWr   = fieldWr;
    strb.fieldSel  = off[2:0];
    strb.fieldData = busWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freezeBit <= 1'b0;
      writeBit  <= 1'b0;
      oscStop   <= 1'b0;
    end else begin
      if (ctlWr) begin
        writeBit  <= busWrData[7];
        freezeBit <= busWrData[6];
      end
      if (fieldWr && (off[2:0] == 3'd0)) oscStop <= busWrData[7];
    end
  end

  always_comb begin
    busRdEn   = winHit && !busCeN && !busOeN && busWeN;
    busRdData = 8'h00;
    if (busRdEn) begin
      if (off == CTL_OFF)                 busRdData = {writeBit, freezeBit, 6'b0};
      else if (off == WIN_BITS'(0))       busRdData = {oscStop, extFlat[6:0]};
      else if (off < CTL_OFF)             busRdData = extFlat[off[2:0]*8 +: 8];
    end
  end

endmodule

// File: rtl/bcd_calendar_regs.sv
module bcd_calendar_regs
  import cal_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int WIN_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busCeN,
  input  logic              busOeN,
  input  logic              busWeN,
  input  logic [7:0]        busWrData,
  input  logic              tick1Hz,
  output logic [7:0]        busRdData,
  output logic              busRdEn,
  output logic              ramCeN
);

  calStrb_t strb;
  calTime_t timeInt;
  calTime_t timeExt;

  cal_control #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busCeN(busCeN),
    .busOeN(busOeN), .busWeN(busWeN), .busWrData(busWrData),
    .tick1Hz(tick1Hz), .timeExt(timeExt), .strb(strb),
    .busRdData(busRdData), .busRdEn(busRdEn), .ramCeN(ramCeN)
  );

  cal_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .timeInt(timeInt), .timeExt(timeExt)
  );

endmodule

// File: rtl/cal_regs_checker.sv
module cal_regs_checker
  import cal_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int WIN_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busCeN,
  input logic              busOeN,
  input logic              busWeN,
  input logic [7:0]        busWrData,
  input logic              tick1Hz,
  input logic [7:0]        busRdData,
  input logic              busRdEn,
  input logic              ramCeN,
  input calStrb_t          strb,
  input calTime_t          timeInt,
  input calTime_t          timeExt
);

  logic                hit;
  logic [WIN_BITS-1:0] off;
  logic                timeWr;
  logic                ctlWr;
  logic                holdMirror;

  assign hit    = &busAddr[ADDR_W-1:WIN_BITS];
  assign off    = busAddr[WIN_BITS-1:0];
  assign timeWr = hit && !busCeN && !busWeN && (off < WIN_BITS'(8));
  assign ctlWr  = hit && !busCeN && !busWeN && (off == WIN_BITS'(8));

  always_ff @(posedge clk) begin
    if (!rstN) holdMirror <= 1'b0;
    else if (ctlWr) holdMirror <= busWrData[7] | busWrData[6];
  end

  assert_ram_blocked_R1: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> ramCeN);

  assert_read_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn |-> (hit && !busCeN && !busOeN && busWeN));

  assert_read_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> (busRdData == 8'h00));

  assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tick1Hz && !strb.transfer) |=> $stable(timeInt));

  assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (holdMirror && !timeWr && !ctlWr) |=> $stable(timeExt));

  assert_transfer_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.transfer |=> (timeInt == $past(timeExt)));

endmodule

bind bcd_calendar_regs cal_regs_checker #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busCeN(busCeN), .busOeN(busOeN),
  .busWeN(busWeN), .busWrData(busWrData), .tick1Hz(tick1Hz),
  .busRdData(busRdData), .busRdEn(busRdEn), .ramCeN(ramCeN),
  .strb(strb), .timeInt(timeInt), .timeExt(timeExt)
);

// File: tb/bcd_calendar_regs_bench.sv
module bcd_calendar_regs_bench;

  localparam int ADDR_W   = 19;
  localparam int WIN_BITS = 4;
  localparam int NVEC     = 12;

  // {start time, expected after one tick}; bytes: century,year,month,date,weekday,hour,minute,second
  localparam logic [127:0] VEC [NVEC] = '{
    {64'h20_24_02_28_03_10_15_30, 64'h20_24_02_28_03_10_15_31},
    {64'h20_24_02_28_03_23_59_59, 64'h20_24_02_29_04_00_00_00},
    {64'h20_23_02_28_07_23_59_59, 64'h20_23_03_01_01_00_00_00},
    {64'h20_00_02_28_01_23_59_59, 64'h20_00_02_29_02_00_00_00},
    {64'h21_00_02_28_01_23_59_59, 64'h21_00_03_01_02_00_00_00},
    {64'h19_99_12_31_05_23_59_59, 64'h20_00_01_01_06_00_00_00},
    {64'h20_25_04_30_02_23_59_59, 64'h20_25_05_01_03_00_00_00},
    {64'h20_25_01_31_02_23_59_59, 64'h20_25_02_01_03_00_00_00},
    {64'h39_99_12_31_07_23_59_59, 64'h00_00_01_01_01_00_00_00},
    {64'h20_25_06_15_04_12_59_59, 64'h20_25_06_15_04_13_00_00},
    {64'h20_25_11_30_04_23_59_59, 64'h20_25_12_01_05_00_00_00},
    {64'h20_25_11_29_04_23_59_59, 64'h20_25_11_30_05_00_00_00}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busCeN = 1'b1;
  logic              busOeN = 1'b1;
  logic              busWeN = 1'b1;
  logic [7:0]        busWrData = 8'h00;
  logic              tick1Hz = 1'b0;
  logic [7:0]        busRdData;
  logic              busRdEn;
  logic              ramCeN;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  bcd_calendar_regs #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_bcd_calendar_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busCeN(busCeN), .busOeN(busOeN),
    .busWeN(busWeN), .busWrData(busWrData), .tick1Hz(tick1Hz),
    .busRdData(busRdData), .busRdEn(busRdEn), .ramCeN(ramCeN)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [ADDR_W-1:0] winAddr(input logic [3:0] o);
    return {{(ADDR_W-4){1'b1}}, o};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] o, input logic [7:0] d);
    @(negedge clk);
    busAddr = winAddr(o); busWrData = d; busCeN = 1'b0; busWeN = 1'b0;
    @(negedge clk);
    busCeN = 1'b1; busWeN = 1'b1;
  endtask

  task automatic busRead(input logic [3:0] o, output logic [7:0] d);
    @(negedge clk);
    busAddr = winAddr(o); busCeN = 1'b0; busOeN = 1'b0; busWeN = 1'b1;
    #1 d = busRdData;
    busCeN = 1'b1; busOeN = 1'b1;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick1Hz = 1'b1;
      @(negedge clk); tick1Hz = 1'b0;
    end
  endtask

  task automatic loadTime(input logic [63:0] t);
    busWrite(4'd8, 8'h80);
    for (int f = 0; f < 8; f++) busWrite(4'(f), t[f*8 +: 8]);
    busWrite(4'd8, 8'h00);
  endtask

  task automatic readTime(output logic [63:0] t);
    logic [7:0] b;
    for (int f = 0; f < 8; f++) begin
      busRead(4'(f), b);
      t[f*8 +: 8] = b;
    end
  endtask

  initial begin
    logic [63:0] t;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    readTime(t);
    check("R10 reset time", t, 64'h20_00_01_01_01_00_00_00);
    busRead(4'd8, b);
    check("R10 reset control", {56'd0, b}, 64'h0);

    // R1 steering and R2 read gating
    @(negedge clk);
    busAddr = 19'h12345; busCeN = 1'b0;
    #1 check("R1 outside window passes CE", {62'd0, ramCeN, busRdEn}, 64'h0);
    busAddr = winAddr(4'd3);
    #1 check("R1 window blocks RAM CE", {63'd0, ramCeN}, 64'h1);
    check("R2 no read without OE", {56'd0, busRdEn, busRdData[6:0]}, 64'h0);
    busOeN = 1'b0; busWeN = 1'b0; busAddr = winAddr(4'd9);
    #1 check("R2 no read while WE active", {56'd0, busRdEn, busRdData[6:0]}, 64'h0);
    busCeN = 1'b1; busOeN = 1'b1; busWeN = 1'b1; busAddr = 19'h12345;
    #1 check("R1 CE inactive outside window", {63'd0, ramCeN}, 64'h1);
    busRead(4'd9, b);
    check("R2 unused offset reads zero", {56'd0, b}, 64'h0);

    // R6/R7 rollover table
    for (int i = 0; i < NVEC; i++) begin
      loadTime(VEC[i][127:64]);
      tick(1);
      readTime(t);
      check($sformatf("R6 R7 vector %0d", i), t, VEC[i][63:0]);
    end

    // R4 freeze, R3 internal keeps running, R9 refresh on next tick
    loadTime(64'h20_25_06_15_04_12_00_00);
    busWrite(4'd8, 8'h40);
    tick(3);
    busRead(4'd0, b);
    check("R4 frozen seconds", {56'd0, b}, 64'h00);
    busWrite(4'd8, 8'h00);
    busRead(4'd0, b);
    check("R9 no refresh before tick", {56'd0, b}, 64'h00);
    tick(1);
    busRead(4'd0, b);
    check("R3 R9 internal advanced through freeze", {56'd0, b}, 64'h04);

    // R5 write mode hold and transfer
    busWrite(4'd8, 8'h80);
    busWrite(4'd0, 8'h10);
    tick(2);
    busRead(4'd0, b);
    check("R5 ext held in write mode", {56'd0, b}, 64'h10);
    busWrite(4'd8, 8'h00);
    tick(1);
    busRead(4'd0, b);
    check("R5 transferred value advances", {56'd0, b}, 64'h11);

    // R8 oscillator stop
    busWrite(4'd8, 8'h80);
    busWrite(4'd0, 8'hA0);
    busWrite(4'd8, 8'h00);
    tick(2);
    busRead(4'd0, b);
    check("R8 stopped time holds", {56'd0, b}, 64'hA0);
    busWrite(4'd0, 8'h20);
    tick(1);
    busRead(4'd0, b);
    check("R8 restart advances", {56'd0, b}, 64'h21);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule